// File: doc/BRIEF.md
# Chip-Select and Wait-State Generator

This block sits beside a bus unit on a 20-bit address bus. It turns each bus address into active-low selects for four targets: an upper memory window that always ends at the top of the address space, a lower memory window that starts at address zero, a bank of seven small peripheral windows, and an internal select for the on-chip peripheral control registers. For the same address it works out how many wait states the bus cycle needs. It also decides whether the cycle has to wait for an external ready. While the cycle must be stretched, it drives a cycle-extend signal back to the bus unit.

Software writes five configuration registers through a simple write port. These set the window sizes and bases, the wait count, a ready-ignore flag, a flag that stops the address from being driven during the cycle, an address-output mode for two peripheral pins, and a pin-function mask. The upper window is live straight out of reset, so the first instruction fetch near the top of memory is decoded with conservative timing. A bus cycle starts with a one-cycle `cyc_start` pulse that carries the address. The selects stay registered until the cycle completes.

Top module: `csw_gen`

## Requirements
- R1: After reset, the upper select covers F0000h to FFFFFh with 3 wait states and ready required. The lower and peripheral selects are disabled, the pin mask is clear, and the control-register select base is 0FFh, which covers 0FF00h to 0FFFFh.
- R2: Register 0 controls the upper window. Bits [6:4] are a size code, where 0, 1, 2 and 3 give 64, 128, 256 and 512 KB windows ending at FFFFFh. A code of 4 to 7 leaves the previous size unchanged. In register 0 and in registers 1 and 2, bits [1:0] hold the wait count and bit 2 set means external ready is ignored.
- R3: Register 1 controls the lower window. Bit 4 enables it, and bits [7:5] are a size code with the same encoding as R2, giving a window from 0 to (64 KB shifted left by the code) minus 1. Illegal codes are ignored.
- R4: A cycle with wait count w and no ready stall holds `cyc_extend` high for exactly w cycles after the edge that accepts it, then completes one cycle later.
- R5: Ready is `ardy` OR `srdy`. It is looked at only once the wait count has run out. When ready is required, the cycle stays extended for every cycle in which ready is low.
- R6: Bit 3 of register 0 and of register 1 is a disable-address flag. If the flag is set on an active select, `ad_drive_en` is low for the whole cycle, even when other selects also match.
- R7: Register 3 bits [11:0] match address bits [19:8] to form `pcb_cs_n`. A cycle that hits only this select has zero waits and ignores ready.
- R8: Register 2 bits [15:6] match address bits [19:10], and bit 3 enables the bank. Peripheral select i (i = 0..6) covers base + 128*i up to base + 128*i + 127. All seven selects share the wait count and ready flag from register 2.
- R9: Register 2 bit 4 is the address mode. When it is set, `pcs_n[5]` outputs address bit 1 and `pcs_n[6]` outputs address bit 2 of the current cycle. Hits in those two windows then add no waits and no ready requirement.
- R10: Register 4 bits [6:0] mark peripheral pins that serve another function. A marked pin stays high, but its window's wait and ready settings still apply.
- R11: When several selects match, the cycle uses the largest wait count among them, and it requires ready if any of them requires it.
- R12: Selects are asserted from the accepting edge until the edge that completes the cycle. A `cyc_start` that arrives during a cycle is ignored. When the block is idle, all selects are high (except pins in address mode), and both `cyc_extend` and `ad_drive_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register number 0..4 |
| cfg_wdata | input | 16 | Configuration write data |
| cyc_start | input | 1 | Bus cycle start pulse, address valid |
| bus_addr | input | 20 | Bus address |
| ardy | input | 1 | Asynchronous ready |
| srdy | input | 1 | Synchronous ready |
| ucs_n | output | 1 | Upper memory select, active low |
| lcs_n | output | 1 | Lower memory select, active low |
| pcs_n | output | 7 | Peripheral selects, active low, or address bits in address mode |
| pcb_cs_n | output | 1 | Internal control-register select, active low |
| ad_drive_en | output | 1 | Address may be driven onto the multiplexed bus |
| cyc_extend | output | 1 | Cycle must be stretched |

## Verification
The bench builds the block with its defaults: a 20-bit address and seven peripheral selects. With these values all four size codes reach the real top and bottom of the address space, so both edges of every window can be tested, including the 512 KB case where the upper and lower windows meet at 80000h. Seven peripheral selects include both address-mode pins (5 and 6) next to ordinary ones, so pin mask, address mode and overlap merging can be tested together. A 2-bit wait field keeps every wait count from 0 to 3 within reach, and each count is tested both with ready held high and with ready held low for several cycles.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int WAIT_W      = 2;
    localparam int CFG_W       = 16;
    localparam int SEL_W       = 3;
    localparam int REGION_LOG  = 16;  // smallest memory window is 64 KB
    localparam int PER_WIN_LOG = 10;  // peripheral bank base granularity
    localparam int PER_BLK_LOG = 7;   // 128 bytes per peripheral select
    localparam int PCB_LOG     = 8;   // control-register window size
    localparam int A1_PIN      = 5;
    localparam int A2_PIN      = 6;

    typedef enum logic [SEL_W-1:0] {
        REG_UPPER = 3'd0,
        REG_LOWER = 3'd1,
        REG_PER   = 3'd2,
        REG_PCB   = 3'd3,
        REG_PIN   = 3'd4
    } cfg_reg_e;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              ign_rdy;
        logic              no_addr;
        logic              en;
        logic [1:0]        size;
    } region_cfg_t;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              ign_rdy;
        logic              en;
        logic              addr_mode;
    } per_cfg_t;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              need_rdy;
    } timing_t;

    function automatic logic size_legal(input logic [2:0] code);
        return code < 3'd4;
    endfunction

    function automatic timing_t tmerge(input timing_t a, input timing_t b);
        timing_t r;
        r.waits    = (a.waits > b.waits) ? a.waits : b.waits;
        r.need_rdy = a.need_rdy | b.need_rdy;
        return r;
    endfunction

endpackage

// File: rtl/csw_cfg_regs.sv
module csw_cfg_regs
    import csw_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PER_N  = 7,
    localparam int PB_W  = ADDR_W - PER_WIN_LOG,
    localparam int PCB_W = ADDR_W - PCB_LOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output region_cfg_t       up_cfg,
    output region_cfg_t       lo_cfg,
    output per_cfg_t          per_cfg,
    output logic [PB_W-1:0]   per_base,
    output logic [PCB_W-1:0]  pcb_base,
    output logic [PER_N-1:0]  pin_mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_cfg   <= '{waits: 2'd3, ign_rdy: 1'b0, no_addr: 1'b0, en: 1'b1, size: 2'd0};
            lo_cfg   <= '{waits: 2'd0, ign_rdy: 1'b0, no_addr: 1'b0, en: 1'b0, size: 2'd0};
            per_cfg  <= '0;
            per_base <= '0;
            pcb_base <= PCB_W'(12'h0FF);
            pin_mask <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == REG_UPPER) begin
                up_cfg.waits   <= cfg_wdata[1:0];
                up_cfg.ign_rdy <= cfg_wdata[2];
                up_cfg.no_addr <= cfg_wdata[3];
                if (size_legal(cfg_wdata[6:4])) up_cfg.size <= cfg_wdata[5:4];
            end else if (cfg_sel == REG_LOWER) begin
                lo_cfg.waits   <= cfg_wdata[1:0];
                lo_cfg.ign_rdy <= cfg_wdata[2];
                lo_cfg.no_addr <= cfg_wdata[3];
                lo_cfg.en      <= cfg_wdata[4];
                if (size_legal(cfg_wdata[7:5])) lo_cfg.size <= cfg_wdata[6:5];
            end else if (cfg_sel == REG_PER) begin
                per_cfg.waits     <= cfg_wdata[1:0];
                per_cfg.ign_rdy   <= cfg_wdata[2];
                per_cfg.en        <= cfg_wdata[3];
                per_cfg.addr_mode <= cfg_wdata[4];
                per_base          <= cfg_wdata[CFG_W-1 -: PB_W];
            end else if (cfg_sel == REG_PCB) begin
                pcb_base <= cfg_wdata[PCB_W-1:0];
            end else if (cfg_sel == REG_PIN) begin
                pin_mask <= cfg_wdata[PER_N-1:0];
            end
        end
    end

    AST_UPPER_RESET_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (up_cfg.en && up_cfg.size == 2'd0 && up_cfg.waits == 2'd3 && !up_cfg.ign_rdy)); // R1

    AST_ILLEGAL_SIZE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == REG_UPPER && cfg_wdata[6]) |=> $stable(up_cfg.size)); // R2

endmodule

// File: rtl/csw_decode.sv
module csw_decode
    import csw_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PER_N  = 7,
    localparam int PB_W  = ADDR_W - PER_WIN_LOG,
    localparam int PCB_W = ADDR_W - PCB_LOG,
    localparam int IDX_W = PER_WIN_LOG - PER_BLK_LOG
) (
    input  logic [ADDR_W-1:0] addr,
    input  region_cfg_t       up_cfg,
    input  region_cfg_t       lo_cfg,
    input  per_cfg_t          per_cfg,
    input  logic [PB_W-1:0]   per_base,
    input  logic [PCB_W-1:0]  pcb_base,
    output logic              up_hit,
    output logic              lo_hit,
    output logic [PER_N-1:0]  per_hit,
    output logic              pcb_hit,
    output logic              no_addr,
    output timing_t           tim
);

    logic [ADDR_W-1:0] up_mask, lo_mask;
    logic              per_win;
    logic [IDX_W-1:0]  per_idx;
    logic [PER_N-1:0]  per_exempt;
    logic              per_timed;

    always_comb begin
        up_mask = {ADDR_W{1'b1}} << (REGION_LOG + int'(up_cfg.size));
        lo_mask = {ADDR_W{1'b1}} << (REGION_LOG + int'(lo_cfg.size));
    end

    assign up_hit  = up_cfg.en && ((addr & up_mask) == up_mask);
    assign lo_hit  = lo_cfg.en && ((addr & lo_mask) == '0);
    assign pcb_hit = (addr[ADDR_W-1:PCB_LOG] == pcb_base);
    assign per_win = per_cfg.en && (addr[ADDR_W-1:PER_WIN_LOG] == per_base);
    assign per_idx = addr[PER_WIN_LOG-1:PER_BLK_LOG];

    for (genvar i = 0; i < PER_N; i++) begin : g_per
        assign per_hit[i] = per_win && (per_idx == IDX_W'(i));
        if (i == A1_PIN || i == A2_PIN) begin : g_addr_pin
            assign per_exempt[i] = per_cfg.addr_mode;
        end else begin : g_plain_pin
            assign per_exempt[i] = 1'b0;
        end
    end

    assign per_timed = |(per_hit & ~per_exempt);
    assign no_addr   = (up_hit && up_cfg.no_addr) || (lo_hit && lo_cfg.no_addr);

    always_comb begin
        tim = '0;
        if (up_hit)
            tim = tmerge(tim, '{waits: up_cfg.waits, need_rdy: !up_cfg.ign_rdy});
        if (lo_hit)
            tim = tmerge(tim, '{waits: lo_cfg.waits, need_rdy: !lo_cfg.ign_rdy});
        if (per_timed)
            tim = tmerge(tim, '{waits: per_cfg.waits, need_rdy: !per_cfg.ign_rdy});
    end

endmodule

// File: rtl/csw_wait_ctrl.sv
module csw_wait_ctrl
    import csw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  timing_t tim,
    input  logic    rdy,
    output logic    accept,
    output logic    active,
    output logic    extend
);

    logic [WAIT_W-1:0] cnt;
    logic              need;

    assign accept = start && !active;
    assign extend = active && ((cnt != '0) || (need && !rdy));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            need   <= 1'b0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                cnt    <= tim.waits;
                need   <= tim.need_rdy;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (!need || rdy) begin
            active <= 1'b0;
        end
    end

    AST_WAIT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (active && cnt != '0) |=> (active && cnt == $past(cnt) - 1'b1)); // R4

    AST_READY_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (active && cnt == '0 && need && !rdy) |=> active); // R5

    AST_NO_READY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (active && cnt == '0 && !need) |=> !active); // R5

    AST_IDLE_NO_EXTEND: assert property (@(posedge clk) disable iff (rst)
        !active |-> !extend); // R12

endmodule

// File: rtl/csw_gen.sv
module csw_gen
    import csw_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PER_N  = 7,
    localparam int PB_W  = ADDR_W - PER_WIN_LOG,
    localparam int PCB_W = ADDR_W - PCB_LOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ardy,
    input  logic              srdy,
    output logic              ucs_n,
    output logic              lcs_n,
    output logic [PER_N-1:0]  pcs_n,
    output logic              pcb_cs_n,
    output logic              ad_drive_en,
    output logic              cyc_extend
);

    region_cfg_t      up_cfg, lo_cfg;
    per_cfg_t         per_cfg;
    logic [PB_W-1:0]  per_base;
    logic [PCB_W-1:0] pcb_base;
    logic [PER_N-1:0] pin_mask;

    logic             up_hit, lo_hit, pcb_hit, no_addr;
    logic [PER_N-1:0] per_hit;
    timing_t          tim;

    logic             accept, active;
    logic             up_q, lo_q, pcb_q, no_addr_q, a1_q, a2_q;
    logic [PER_N-1:0] per_q;

    csw_cfg_regs #(.ADDR_W(ADDR_W), .PER_N(PER_N)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .up_cfg(up_cfg), .lo_cfg(lo_cfg), .per_cfg(per_cfg),
        .per_base(per_base), .pcb_base(pcb_base), .pin_mask(pin_mask)
    );

    csw_decode #(.ADDR_W(ADDR_W), .PER_N(PER_N)) u_dec (
        .addr(bus_addr), .up_cfg(up_cfg), .lo_cfg(lo_cfg), .per_cfg(per_cfg),
        .per_base(per_base), .pcb_base(pcb_base),
        .up_hit(up_hit), .lo_hit(lo_hit), .per_hit(per_hit), .pcb_hit(pcb_hit),
        .no_addr(no_addr), .tim(tim)
    );

    csw_wait_ctrl u_wait (
        .clk(clk), .rst(rst), .start(cyc_start), .tim(tim), .rdy(ardy | srdy),
        .accept(accept), .active(active), .extend(cyc_extend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q      <= 1'b0;
            lo_q      <= 1'b0;
            pcb_q     <= 1'b0;
            per_q     <= '0;
            no_addr_q <= 1'b0;
            a1_q      <= 1'b0;
            a2_q      <= 1'b0;
        end else if (accept) begin
            up_q      <= up_hit;
            lo_q      <= lo_hit;
            pcb_q     <= pcb_hit;
            per_q     <= per_hit;
            no_addr_q <= no_addr;
            a1_q      <= bus_addr[1];
            a2_q      <= bus_addr[2];
        end
    end

    assign ucs_n       = !(active && up_q);
    assign lcs_n       = !(active && lo_q);
    assign pcb_cs_n    = !(active && pcb_q);
    assign ad_drive_en = active && !no_addr_q;

    for (genvar i = 0; i < PER_N; i++) begin : g_pin
        if (i == A1_PIN) begin : g_a1
            assign pcs_n[i] = per_cfg.addr_mode ? a1_q : !(active && per_q[i] && !pin_mask[i]);
        end else if (i == A2_PIN) begin : g_a2
            assign pcs_n[i] = per_cfg.addr_mode ? a2_q : !(active && per_q[i] && !pin_mask[i]);
        end else begin : g_sel
            assign pcs_n[i] = !(active && per_q[i] && !pin_mask[i]);
        end
    end

    AST_IDLE_SELECTS_OFF: assert property (@(posedge clk) disable iff (rst)
        !active |-> (ucs_n && lcs_n && pcb_cs_n && !ad_drive_en)); // R12

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (active && cyc_extend) |=> ($stable(ucs_n) && $stable(lcs_n) && $stable(pcb_cs_n))); // R12

endmodule

// File: tb/csw_gen_tb_top.sv
`timescale 1ns/1ps
module csw_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic        cyc_start;
    logic [19:0] bus_addr;
    logic        ardy, srdy;
    logic        ucs_n, lcs_n, pcb_cs_n, ad_drive_en, cyc_extend;
    logic [6:0]  pcs_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // shadow configuration, kept from the requirements
    int u_w, u_sz, l_w, l_sz, p_w, p_base, pcb_base;
    bit u_ign, u_da, l_ign, l_da, l_en, p_ign, p_en, p_am;
    bit [6:0] pin;

    always #4 clk = ~clk;

    csw_gen dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cyc_start(cyc_start), .bus_addr(bus_addr), .ardy(ardy), .srdy(srdy),
        .ucs_n(ucs_n), .lcs_n(lcs_n), .pcs_n(pcs_n), .pcb_cs_n(pcb_cs_n),
        .ad_drive_en(ad_drive_en), .cyc_extend(cyc_extend)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int win(input int code);
        return 32'h10000 << code;
    endfunction

    function automatic bit m_up(input int a);
        return a >= (32'h100000 - win(u_sz));
    endfunction

    function automatic bit m_lo(input int a);
        return l_en && (a < win(l_sz));
    endfunction

    function automatic bit m_per(input int a, input int i);
        int lo;
        lo = p_base * 1024 + 128 * i;
        return p_en && (a >= lo) && (a < lo + 128);
    endfunction

    function automatic bit m_pcb(input int a);
        return (a / 256) == pcb_base;
    endfunction

    function automatic int m_waits(input int a, output bit need);
        int w;
        w = 0; need = 0;
        if (m_up(a)) begin if (u_w > w) w = u_w; need |= !u_ign; end
        if (m_lo(a)) begin if (l_w > w) w = l_w; need |= !l_ign; end
        for (int i = 0; i < 7; i++)
            if (m_per(a, i) && !(p_am && (i == 5 || i == 6))) begin
                if (p_w > w) w = p_w;
                need |= !p_ign;
            end
        return w;
    endfunction

    function automatic int m_pcs(input int a, input bit act);
        int v;
        v = 0;
        for (int i = 0; i < 7; i++) begin
            if (p_am && i == 5)      v |= ((a >> 1) & 1) << i;
            else if (p_am && i == 6) v |= ((a >> 2) & 1) << i;
            else                     v |= (!(act && m_per(a, i) && !pin[i])) << i;
        end
        return v;
    endfunction

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_upper(input int w, input bit ign, input bit da, input int code);
        wr(0, w | (ign << 2) | (da << 3) | (code << 4));
        u_w = w; u_ign = ign; u_da = da;
        if (code < 4) u_sz = code;
    endtask

    task automatic set_lower(input int w, input bit ign, input bit da, input bit en, input int code);
        wr(1, w | (ign << 2) | (da << 3) | (en << 4) | (code << 5));
        l_w = w; l_ign = ign; l_da = da; l_en = en;
        if (code < 4) l_sz = code;
    endtask

    task automatic set_per(input int w, input bit ign, input bit en, input bit am, input int base);
        wr(2, w | (ign << 2) | (en << 3) | (am << 4) | (base << 6));
        p_w = w; p_ign = ign; p_en = en; p_am = am; p_base = base;
    endtask

    task automatic set_pcb(input int base);
        wr(3, base); pcb_base = base;
    endtask

    task automatic set_pin(input int m);
        wr(4, m); pin = 7'(m);
    endtask

    // One bus cycle. Ready is held low for the first w+stall cycles, then high.
    task automatic run_cycle(input int a, input int stall, input bit poke, input string tag);
        int  w, n, exp_ext;
        bit  need;
        w = m_waits(a, need);
        exp_ext = w + (need ? stall : 0);
        @(negedge clk);
        bus_addr = 20'(a); cyc_start = 1; ardy = 0; srdy = 0;
        @(negedge clk);
        cyc_start = 0;
        n = 0;
        for (int j = 0; j < 40; j++) begin
            if (j >= w + stall) begin
                if ($urandom_range(1)) ardy = 1; else srdy = 1;
            end else begin
                ardy = 0; srdy = 0;
            end
            #1;
            if (j == 0 || j == 1) begin
                check("R2 upper select", int'(ucs_n), int'(!m_up(a)));
                check("R3 lower select", int'(lcs_n), int'(!m_lo(a)));
                check("R8 peripheral selects", int'(pcs_n), m_pcs(a, 1));
                check("R7 control select", int'(pcb_cs_n), int'(!m_pcb(a)));
                check("R6 address drive", int'(ad_drive_en),
                      int'(!((m_up(a) && u_da) || (m_lo(a) && l_da))));
            end
            if (!cyc_extend) break;
            n++;
            if (j == 0 && poke) begin
                bus_addr = 20'(a ^ 32'hFFFFF); cyc_start = 1;
            end
            @(negedge clk);
            cyc_start = 0;
        end
        check(tag, n, exp_ext);
        @(negedge clk);
        ardy = 0; srdy = 0;
        #1;
        check("R12 idle selects", int'({ucs_n, lcs_n, pcb_cs_n, ad_drive_en, cyc_extend}), 5'b11100);
        check("R12 idle peripheral pins", int'(pcs_n), m_pcs(a, 0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd20250);
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        cyc_start = 0; bus_addr = 0; ardy = 0; srdy = 0;
        u_w = 3; u_ign = 0; u_da = 0; u_sz = 0;
        l_w = 0; l_ign = 0; l_da = 0; l_en = 0; l_sz = 0;
        p_w = 0; p_ign = 0; p_en = 0; p_am = 0; p_base = 0;
        pcb_base = 'h0FF; pin = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check("R1 reset outputs", int'({ucs_n, lcs_n, pcb_cs_n, ad_drive_en, cyc_extend}), 5'b11100);
        check("R1 reset peripheral pins", int'(pcs_n), 7'h7F);

        // reset fetch: 3 waits, ready required
        run_cycle('hFFFF0, 0, 0, "R1 reset fetch waits");
        run_cycle('hFFFF0, 4, 1, "R5 reset fetch ready stall");
        run_cycle('hF0000, 0, 0, "R1 upper low edge");
        run_cycle('hEFFFF, 0, 0, "R1 below upper");
        run_cycle('h0FF00, 2, 0, "R7 control select zero wait");

        // upper size codes and illegal code
        set_upper(1, 0, 0, 2);
        run_cycle('hC0000, 0, 0, "R2 256K low edge");
        run_cycle('hBFFFF, 0, 0, "R2 256K miss");
        set_upper(2, 1, 0, 6);
        run_cycle('hC0000, 3, 0, "R2 illegal code keeps size");
        run_cycle('hFFFFF, 3, 0, "R5 ready ignored");

        // lower window with disable-address flag
        set_lower(1, 0, 1, 1, 1);
        run_cycle('h1FFFF, 2, 0, "R3 lower top edge");
        run_cycle('h20000, 0, 0, "R3 lower miss");
        run_cycle('h00000, 0, 0, "R6 lower no address");
        set_lower(1, 0, 1, 1, 7);
        run_cycle('h1FFFF, 0, 0, "R3 illegal code keeps size");
        for (int w = 0; w < 4; w++) begin
            set_lower(w, 0, 0, 1, 0);
            run_cycle('h00100, 0, 0, "R4 wait count");
            run_cycle('h00100, 3, 0, "R5 wait then stall");
        end

        // peripheral bank
        set_lower(0, 0, 0, 0, 0);
        set_per(2, 0, 1, 0, 'h010);
        run_cycle('h04000, 0, 0, "R8 peripheral first");
        run_cycle('h0437F, 1, 0, "R8 peripheral last");
        run_cycle('h04380, 0, 0, "R8 peripheral miss");
        set_per(2, 0, 1, 1, 'h010);
        run_cycle('h042A6, 3, 0, "R9 address-mode pin no waits");
        run_cycle('h0430C, 3, 0, "R9 address-mode pin six");
        run_cycle('h04100, 1, 0, "R9 other pin keeps waits");
        set_pin('h01);
        run_cycle('h04000, 2, 0, "R10 masked pin keeps timing");

        // overlaps
        set_pcb('hFFF);
        set_upper(1, 1, 1, 0);
        run_cycle('hFFF20, 2, 0, "R11 control overlaps upper");
        set_upper(0, 1, 1, 3);
        set_lower(1, 1, 0, 1, 3);
        set_per(3, 0, 1, 0, 'h100);
        run_cycle('h40010, 2, 0, "R11 lower and peripheral overlap");
        run_cycle('h80000, 0, 0, "R6 upper 512K low edge");
        run_cycle('h7FFFF, 0, 0, "R3 lower 512K top");

        // constrained random configuration and addresses
        for (int it = 0; it < 60; it++) begin
            int pts[6];
            set_upper($urandom_range(3), $urandom_range(1), $urandom_range(1), $urandom_range(7));
            set_lower($urandom_range(3), $urandom_range(1), $urandom_range(1), $urandom_range(1),
                      $urandom_range(7));
            set_per($urandom_range(3), $urandom_range(1), $urandom_range(1), $urandom_range(1),
                    $urandom_range(1023));
            set_pcb($urandom_range(4095));
            set_pin($urandom_range(127));
            pts[0] = 32'h100000 - win(u_sz);
            pts[1] = pts[0] - 1;
            pts[2] = win(l_sz) - 1;
            pts[3] = p_base * 1024 + 128 * $urandom_range(7);
            pts[4] = pcb_base * 256 + $urandom_range(255);
            pts[5] = $urandom_range(32'hFFFFF);
            for (int k = 0; k < 6; k++)
                run_cycle(pts[k] & 32'hFFFFF, $urandom_range(4), $urandom_range(1), "R11 random merge");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule